// File: doc/BRIEF.md
# Array Write-Protection and Status Register Unit

This unit holds the write-enable latch of a serial memory together with three protection bits: a two-bit block-protection level and a pin-lock enable. It assembles the status byte that a read-status command shifts out, and for every request it answers two questions. May the array address now on the probe input be programmed? May the status register be rewritten?

The command sequencer around the unit drives one-cycle strobes. One strobe sets the latch and one clears it. A commit strobe carries the data of a status write. A completion strobe marks the end of an internal programming cycle. The sequencer also supplies the busy level and the active-low write-protect pin.

The protection bits would be nonvolatile in silicon. Here they take parameter values at reset. A status write that is permitted at its commit updates the bits on the next clock edge. From then on the pin has no further say over that write.

Top module: `sr_prot_unit`

## Requirements
- R1: While `busy` is low, `status` reads {lock-enable, 0, 0, 0, level[1], level[0], write-enable latch, 0}: bit 7 is the lock enable, bits 3:2 are the level, bit 1 is the latch, and bit 0 is 0 when idle.
- R2: While `busy` is high, `status` reads 8'hFF.
- R3: Level 2'b00 protects no address. Level 2'b01 protects addresses whose top two bits are 2'b11 (3000–3FFF for 14 bits). Level 2'b10 protects addresses whose top bit is 1 (2000–3FFF). Level 2'b11 protects every address.
- R4: `arr_ok` is high only when the latch is set, `busy` is low and `probe_addr` is not protected. A protected address is never permitted, even with the latch set.
- R5: `sr_ok` is high only when the latch is set, `busy` is low, and the lock is not active. The lock is active when the lock-enable bit is 1 and `wp_n` is 0. A `sr_commit` while `sr_ok` is high loads `sr_wdata[7]` into the lock enable and `sr_wdata[3:2]` into the level, visible in `status` from the next cycle. Otherwise the commit leaves them unchanged.
- R6: If `wp_n` is low at commit while the lock enable is 1, the status write is dropped. Lowering `wp_n` after an accepted commit leaves the new bits in place.
- R7: The latch is 0 after reset. `wen_set` sets it. `wen_clr` clears it whatever `wp_n` is, and `wen_clr` wins over a simultaneous `wen_set`.
- R8: While `busy` is high, `wen_set`, `wen_clr` and `sr_commit` have no effect.
- R9: A `cyc_done` pulse clears the latch, and it overrides `wen_set`.
- R10: Reset loads the level from `RST_LEVEL` and the lock enable from `RST_LOCK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wen_set | input | 1 | Strobe: set write-enable latch |
| wen_clr | input | 1 | Strobe: clear write-enable latch |
| sr_commit | input | 1 | Strobe: status write ends, apply `sr_wdata` |
| sr_wdata | input | 8 | Status write data |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal programming cycle in progress |
| cyc_done | input | 1 | Strobe: programming cycle finished |
| probe_addr | input | ADDR_W | Array address under test |
| status | output | 8 | Status byte |
| arr_ok | output | 1 | Array write permitted at `probe_addr` |
| sr_ok | output | 1 | Status write permitted |

## Verification
The assertions assume that the strobes are single-cycle pulses from a sequencer that accepts a commit only at a command boundary. They also assume that `cyc_done` is raised only as `busy` ends, so the completion pulse is never taken as a new command. The directed stimulus holds to this. It changes inputs on the falling edge, pulses each strobe for exactly one cycle, and raises `busy` only between commands. Strobes issued during `busy` are deliberate, and the bench reads the result only after `busy` drops.

// File: rtl/sr_prot_pkg.sv
package sr_prot_pkg;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] level;
        logic       wel;
    } sr_state_t;

    // Level decode on the two most significant address bits.
    function automatic logic level_hits(input logic [1:0] level, input logic [1:0] top2);
        case (level)
            2'b01:   return (top2 == 2'b11);
            2'b10:   return top2[1];
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sr_prot_decode.sv
module sr_prot_decode #(
    parameter int ADDR_W = 14
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    import sr_prot_pkg::*;

    localparam int TOP = ADDR_W - 1;

    logic [1:0] top2;

    always_comb begin
        top2 = addr[TOP -: 2];
        hit  = level_hits(level, top2);
    end
endmodule

// File: rtl/sr_status_fmt.sv
module sr_status_fmt (
    input  sr_prot_pkg::sr_state_t st,
    input  logic                   busy,
    output logic [7:0]             byte_o
);
    always_comb begin
        if (busy) begin
            byte_o = 8'hFF;
        end else begin
            byte_o = {st.lock_en, 3'b000, st.level, st.wel, 1'b0};
        end
    end
endmodule

// File: rtl/sr_prot_unit.sv
module sr_prot_unit #(
    parameter int         ADDR_W    = 14,
    parameter logic [1:0] RST_LEVEL = 2'b00,
    parameter logic       RST_LOCK  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_set,
    input  logic              wen_clr,
    input  logic              sr_commit,
    input  logic [7:0]        sr_wdata,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              cyc_done,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [7:0]        status,
    output logic              arr_ok,
    output logic              sr_ok
);
    import sr_prot_pkg::*;

    localparam int        LOCK_BIT = 7;
    localparam int        LVL_HI   = 3;
    localparam sr_state_t RST_ST   = '{lock_en: RST_LOCK, level: RST_LEVEL, wel: 1'b0};

    sr_state_t st_d, st_q;
    logic      prot_hit;
    logic      hw_lock;

    sr_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
        .level (st_q.level),
        .addr  (probe_addr),
        .hit   (prot_hit)
    );

    sr_status_fmt u_fmt (
        .st     (st_q),
        .busy   (busy),
        .byte_o (status)
    );

    always_comb begin
        hw_lock = st_q.lock_en & ~wp_n;
        arr_ok  = st_q.wel & ~busy & ~prot_hit;
        sr_ok   = st_q.wel & ~busy & ~hw_lock;

        st_d = st_q;
        if (!busy) begin
            if (sr_commit && sr_ok) begin
                st_d.lock_en = sr_wdata[LOCK_BIT];
                st_d.level   = sr_wdata[LVL_HI -: 2];
            end
            if (wen_set) begin
                st_d.wel = 1'b1;
            end
            if (wen_clr) begin
                st_d.wel = 1'b0;
            end
        end
        if (cyc_done) begin
            st_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sr_prot_unit_chk.sv
module sr_prot_unit_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wen_clr,
    input logic              wp_n,
    input logic              busy,
    input logic              cyc_done,
    input logic [ADDR_W-1:0] probe_addr,
    input logic [7:0]        status,
    input logic              arr_ok,
    input logic              sr_ok
);
    p_all_ones_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> status == 8'hFF);

    p_idle_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (status[6:4] == 3'b000 && !status[0]));

    p_no_perm_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!arr_ok && !sr_ok));

    p_wel_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !status[1]) |-> (!arr_ok && !sr_ok));

    p_full_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && status[3:2] == 2'b11) |-> !arr_ok);

    p_quarter_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && status[3:2] == 2'b01 && probe_addr[ADDR_W-1 -: 2] == 2'b11) |-> !arr_ok);

    p_pin_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && status[7] && !wp_n) |-> !sr_ok);

    p_clr_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_clr && !busy) |=> (busy || !status[1]));

    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (busy || !status[1]));
endmodule

bind sr_prot_unit sr_prot_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wen_clr    (wen_clr),
    .wp_n       (wp_n),
    .busy       (busy),
    .cyc_done   (cyc_done),
    .probe_addr (probe_addr),
    .status     (status),
    .arr_ok     (arr_ok),
    .sr_ok      (sr_ok)
);

// File: tb/sr_prot_unit_bench.sv
module sr_prot_unit_bench;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen_set = 1'b0, wen_clr = 1'b0, sr_commit = 1'b0;
    logic [7:0]    sr_wdata = 8'h00;
    logic          wp_n = 1'b1, busy = 1'b0, cyc_done = 1'b0;
    logic [AW-1:0] probe_addr = '0;
    logic [7:0]    status;
    logic          arr_ok, sr_ok;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sr_prot_unit #(.ADDR_W(AW)) u_sr_prot_unit (
        .clk(clk), .rst_n(rst_n), .wen_set(wen_set), .wen_clr(wen_clr),
        .sr_commit(sr_commit), .sr_wdata(sr_wdata), .wp_n(wp_n), .busy(busy),
        .cyc_done(cyc_done), .probe_addr(probe_addr), .status(status),
        .arr_ok(arr_ok), .sr_ok(sr_ok)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Inputs change on the falling edge; the effect is read one falling edge later.
    task automatic strobe(input bit s, input bit c, input bit m, input bit d, input logic [7:0] wd);
        @(negedge clk);
        wen_set = s; wen_clr = c; sr_commit = m; cyc_done = d; sr_wdata = wd;
        @(negedge clk);
        wen_set = 0; wen_clr = 0; sr_commit = 0; cyc_done = 0;
    endtask

    task automatic probe(input string req, input logic [AW-1:0] a, input bit exp);
        probe_addr = a;
        #1;
        chk(req, {7'd0, arr_ok}, {7'd0, exp});
    endtask

    task automatic t_reset;
        chk("R10 R1 R7 reset status", status, 8'h00);
        probe("R4 reset arr_ok", 14'h0000, 1'b0);
        chk("R5 reset sr_ok", {7'd0, sr_ok}, 8'h00);
    endtask

    task automatic t_latch;
        strobe(1, 0, 0, 0, 8'h00);
        chk("R7 set latch", status, 8'h02);
        probe("R4 unprotected ok", 14'h3FFF, 1'b1);
        strobe(1, 1, 0, 0, 8'h00);
        chk("R7 clear wins", status, 8'h00);
        strobe(0, 0, 1, 0, 8'h8C);
        chk("R5 commit without latch dropped", status, 8'h00);
        strobe(1, 0, 0, 0, 8'h00);
    endtask

    task automatic t_levels;
        strobe(0, 0, 1, 0, 8'h04);
        chk("R5 level 01 loaded", status, 8'h06);
        probe("R3 quarter top", 14'h3000, 1'b0);
        probe("R3 quarter below", 14'h2FFF, 1'b1);
        strobe(0, 0, 1, 0, 8'h08);
        chk("R5 level 10 loaded", status, 8'h0A);
        probe("R3 half top", 14'h2000, 1'b0);
        probe("R3 half below", 14'h1FFF, 1'b1);
        strobe(0, 0, 1, 0, 8'h0C);
        probe("R3 all low", 14'h0000, 1'b0);
        strobe(0, 0, 1, 0, 8'h70);
        chk("R1 unused data bits ignored", status, 8'h02);
    endtask

    task automatic t_busy;
        @(negedge clk); busy = 1;
        #1 chk("R2 busy all ones", status, 8'hFF);
        chk("R4 busy no array perm", {7'd0, arr_ok}, 8'h00);
        strobe(0, 1, 1, 0, 8'h8C);
        @(negedge clk); busy = 0;
        #1 chk("R8 busy strobes ignored", status, 8'h02);
        @(negedge clk); busy = 1;
        strobe(0, 0, 0, 1, 8'h00);
        busy = 0;
        #1 chk("R9 done clears latch", status, 8'h00);
        strobe(1, 0, 0, 1, 8'h00);
        chk("R9 done beats set", status, 8'h00);
    endtask

    task automatic t_pin;
        strobe(1, 0, 0, 0, 8'h00);
        strobe(0, 0, 1, 0, 8'h80);
        chk("R5 lock enable loaded", status, 8'h82);
        @(negedge clk); wp_n = 0;
        #1 chk("R5 pin lock sr_ok", {7'd0, sr_ok}, 8'h00);
        strobe(0, 0, 1, 0, 8'h00);
        chk("R6 locked commit dropped", status, 8'h82);
        @(negedge clk); wp_n = 1;
        strobe(0, 0, 1, 0, 8'h84);
        @(negedge clk); wp_n = 0;
        @(negedge clk);
        chk("R6 pin after commit no effect", status, 8'h86);
        strobe(0, 1, 0, 0, 8'h00);
        chk("R7 clear with pin low", status, 8'h84);
        probe("R4 no latch no perm", 14'h0000, 1'b0);
        @(negedge clk); wp_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_levels();
        t_busy();
        t_pin();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule